// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small processor with one architectural register, an accumulator. Every instruction it understands either moves a word between memory and the accumulator or combines a memory word with the accumulator and leaves the result there. Programs are fetched one byte at a time from an instruction store that answers in the same cycle. Data words travel over a separate data port whose read data returns one cycle after the read strobe.

A run starts with a one-cycle `start` pulse. The core fetches from instruction address zero and executes in sequence until it meets a halt opcode or a byte it does not recognise. It then raises `done` and holds its results. Two counters record how many instruction bytes were fetched and how many data bytes were moved. They are meant to compare the code and data traffic of a program, and they stay frozen while `done` is high. A new `start` pulse clears them and begins a fresh run.

Top module: `acc_core`

## Requirements
- R1: After reset `done`, `illegal`, `acc`, `ibyte_cnt` and `dbyte_cnt` are all zero, and neither `dmem_rd` nor `dmem_wr` is asserted.
- R2: Opcode 0x01 (load) replaces the accumulator with the data word at the operand address.
- R3: Opcode 0x02 (store) writes the accumulator to the data word at the operand address and leaves the accumulator unchanged.
- R4: Opcodes 0x10 (add) and 0x11 (subtract, accumulator minus memory) replace the accumulator with the result modulo 2^DATA_W.
- R5: Opcodes 0x12 (bitwise AND) and 0x13 (bitwise OR) combine the accumulator with the memory word and keep the result in the accumulator.
- R6: Every opcode other than halt is followed by two address bytes, low byte first then high byte, so it occupies 3 bytes. Instructions are fetched in sequence from address 0.
- R7: Opcode 0xFF (halt) is one byte long. It raises `done`, which then stays high with the accumulator and both counters held until the next `start`.
- R8: Any other opcode value raises both `done` and `illegal` without any data access. Its single opcode byte is still counted.
- R9: `ibyte_cnt` grows by one for each instruction byte fetched. `dbyte_cnt` grows by DATA_W/8 for each load, store or arithmetic instruction.
- R10: `dmem_rd` and `dmem_wr` are never asserted together, and neither is asserted while `done` is high.
- R11: A `start` pulse given while idle or done clears the accumulator, both counters and `illegal`, and restarts the fetch at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a run |
| imem_addr | output | IADDR_W (16) | Instruction byte address |
| imem_rdata | input | 8 | Instruction byte, valid in the same cycle as its address |
| dmem_addr | output | DADDR_W (16) | Data word address |
| dmem_rd | output | 1 | Data read strobe; data returns on the next cycle |
| dmem_wr | output | 1 | Data write strobe |
| dmem_wdata | output | DATA_W (32) | Write data (the accumulator) |
| dmem_rdata | input | DATA_W (32) | Read data, one cycle after `dmem_rd` |
| acc | output | DATA_W (32) | Accumulator |
| done | output | 1 | Program has stopped |
| illegal | output | 1 | Program stopped on an undefined opcode |
| ibyte_cnt | output | CNT_W (32) | Instruction bytes fetched in this run |
| dbyte_cnt | output | CNT_W (32) | Data bytes transferred in this run |

## Verification
The bench targets five corner cases:
- A program that is a lone halt byte. A core that treated halt as a three-byte instruction would show an instruction count of 3 instead of 1.
- An operand whose two address bytes differ. A core that swapped the bytes would load a neighbouring word with a distinct value.
- A subtraction that passes below zero, which must wrap. A store followed by a load from the same address must return the stored value.
- An undefined opcode after a load. This must stop the run with `illegal` set and a count of only one byte for the bad instruction.
- Back-to-back runs. A core that failed to clear its state on `start` would carry the accumulator or the counts over from the previous run.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam logic [7:0] OPC_LOAD  = 8'h01;
   localparam logic [7:0] OPC_STORE = 8'h02;
   localparam logic [7:0] OPC_ADD   = 8'h10;
   localparam logic [7:0] OPC_SUB   = 8'h11;
   localparam logic [7:0] OPC_AND   = 8'h12;
   localparam logic [7:0] OPC_OR    = 8'h13;
   localparam logic [7:0] OPC_HALT  = 8'hFF;

   typedef enum logic [2:0] {
      CL_LOAD,
      CL_STORE,
      CL_ALU,
      CL_HALT,
      CL_ILLEGAL
   } op_class_e;

   typedef enum logic [1:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR
   } alu_sel_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_OPC,
      S_ALO,
      S_AHI,
      S_MEM,
      S_EXEC,
      S_DONE
   } core_state_e;

   typedef struct packed {
      op_class_e cls;
      alu_sel_e  sel;
   } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
#(
   parameter bit ENABLE_LOGIC = 1'b1
) (
   input  logic [7:0] opcode,
   output dec_t       dec
);

   always_comb begin
      dec.cls = CL_ILLEGAL;
      dec.sel = ALU_ADD;
      case (opcode)
         OPC_LOAD:  dec.cls = CL_LOAD;
         OPC_STORE: dec.cls = CL_STORE;
         OPC_HALT:  dec.cls = CL_HALT;
         OPC_ADD: begin
            dec.cls = CL_ALU;
            dec.sel = ALU_ADD;
         end
         OPC_SUB: begin
            dec.cls = CL_ALU;
            dec.sel = ALU_SUB;
         end
         OPC_AND: begin
            dec.cls = ENABLE_LOGIC ? CL_ALU : CL_ILLEGAL;
            dec.sel = ALU_AND;
         end
         OPC_OR: begin
            dec.cls = ENABLE_LOGIC ? CL_ALU : CL_ILLEGAL;
            dec.sel = ALU_OR;
         end
         default: dec.cls = CL_ILLEGAL;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit ENABLE_LOGIC = 1'b1
) (
   input  alu_sel_e          sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] arith_y;
   logic [DATA_W-1:0] logic_y;

   assign arith_y = (sel == ALU_SUB) ? (a - b) : (a + b);

   generate
      if (ENABLE_LOGIC) begin : g_logic
         assign logic_y = (sel == ALU_AND) ? (a & b) : (a | b);
      end else begin : g_nologic
         assign logic_y = a;
      end
   endgenerate

   assign y = (sel == ALU_ADD || sel == ALU_SUB) ? arith_y : logic_y;

endmodule

// File: rtl/acc_byte_counter.sv
module acc_byte_counter #(
   parameter int CNT_W = 32,
   parameter int STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   generate
      if (STEP < 1) begin : g_bad_step
         $error("acc_byte_counter: STEP must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (inc)  cnt <= cnt + STEP_V;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> (cnt == $past(cnt) || cnt == $past(cnt) + STEP_V)) else $error("counter jumped"); // R9

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int DADDR_W      = 16,
   parameter int IADDR_W      = 16,
   parameter int CNT_W        = 32,
   parameter bit ENABLE_LOGIC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic [IADDR_W-1:0] imem_addr,
   input  logic [7:0]         imem_rdata,
   output logic [DADDR_W-1:0] dmem_addr,
   output logic               dmem_rd,
   output logic               dmem_wr,
   output logic [DATA_W-1:0]  dmem_wdata,
   input  logic [DATA_W-1:0]  dmem_rdata,
   output logic [DATA_W-1:0]  acc,
   output logic               done,
   output logic               illegal,
   output logic [CNT_W-1:0]   ibyte_cnt,
   output logic [CNT_W-1:0]   dbyte_cnt
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OPND_W     = 16;
   localparam logic [IADDR_W-1:0] PC_ONE = IADDR_W'(1);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("acc_core: DATA_W must be a positive multiple of 8");
      end
      if (DADDR_W < 9 || DADDR_W > OPND_W) begin : g_bad_daddr
         $error("acc_core: DADDR_W must lie in 9..16");
      end
      if (IADDR_W < 2) begin : g_bad_iaddr
         $error("acc_core: IADDR_W too small");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("acc_core: CNT_W too small");
      end
   endgenerate

   core_state_e          state_q, state_d;
   logic [IADDR_W-1:0]   pc_q;
   logic [7:0]           alo_q, ahi_q;
   dec_t                 dec_now, dec_q;
   logic [DATA_W-1:0]    acc_q;
   logic [DATA_W-1:0]    alu_y;
   logic                 illegal_q;
   logic                 launch;
   logic                 fetch_byte;
   logic [OPND_W-1:0]    opnd;

   acc_decode #(.ENABLE_LOGIC(ENABLE_LOGIC)) u_dec (
      .opcode (imem_rdata),
      .dec    (dec_now)
   );

   acc_alu #(.DATA_W(DATA_W), .ENABLE_LOGIC(ENABLE_LOGIC)) u_alu (
      .sel (dec_q.sel),
      .a   (acc_q),
      .b   (dmem_rdata),
      .y   (alu_y)
   );

   assign launch     = start && (state_q == S_IDLE || state_q == S_DONE);
   assign fetch_byte = (state_q == S_OPC) || (state_q == S_ALO) || (state_q == S_AHI);

   acc_byte_counter #(.CNT_W(CNT_W), .STEP(1)) u_icnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .inc   (fetch_byte),
      .cnt   (ibyte_cnt)
   );

   acc_byte_counter #(.CNT_W(CNT_W), .STEP(WORD_BYTES)) u_dcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .inc   (state_q == S_MEM),
      .cnt   (dbyte_cnt)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_IDLE: if (launch) state_d = S_OPC;
         S_OPC: begin
            if (dec_now.cls == CL_HALT || dec_now.cls == CL_ILLEGAL) state_d = S_DONE;
            else                                                     state_d = S_ALO;
         end
         S_ALO:  state_d = S_AHI;
         S_AHI:  state_d = S_MEM;
         S_MEM:  state_d = (dec_q.cls == CL_STORE) ? S_OPC : S_EXEC;
         S_EXEC: state_d = S_OPC;
         S_DONE: if (launch) state_d = S_OPC;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         pc_q      <= '0;
         alo_q     <= '0;
         ahi_q     <= '0;
         dec_q     <= '{cls: CL_HALT, sel: ALU_ADD};
         acc_q     <= '0;
         illegal_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (launch) begin
            pc_q      <= '0;
            acc_q     <= '0;
            illegal_q <= 1'b0;
         end
         if (fetch_byte) pc_q <= pc_q + PC_ONE;
         if (state_q == S_OPC) begin
            dec_q <= dec_now;
            if (dec_now.cls == CL_ILLEGAL) illegal_q <= 1'b1;
         end
         if (state_q == S_ALO) alo_q <= imem_rdata;
         if (state_q == S_AHI) ahi_q <= imem_rdata;
         if (state_q == S_EXEC) begin
            if (dec_q.cls == CL_LOAD) acc_q <= dmem_rdata;
            else                      acc_q <= alu_y;
         end
      end
   end

   assign opnd       = {ahi_q, alo_q};
   assign imem_addr  = pc_q;
   assign dmem_addr  = opnd[DADDR_W-1:0];
   assign dmem_rd    = (state_q == S_MEM) && (dec_q.cls != CL_STORE);
   assign dmem_wr    = (state_q == S_MEM) && (dec_q.cls == CL_STORE);
   assign dmem_wdata = acc_q;
   assign acc        = acc_q;
   assign done       = (state_q == S_DONE);
   assign illegal    = illegal_q;

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_rd && dmem_wr)) else $error("read and write together"); // R10

   AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(dmem_rd || dmem_wr)) else $error("data access while done"); // R10

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(acc) && $stable(ibyte_cnt) && $stable(dbyte_cnt))) else $error("done state moved"); // R7

   AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done) else $error("illegal without done"); // R8

   AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_byte || dmem_wr) && !(state_q == S_OPC && $past(state_q) == S_EXEC) |=> $stable(acc))
      else $error("accumulator changed outside execute"); // R3

   AST_DATA_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      (dmem_rd || dmem_wr) |=> dbyte_cnt == $past(dbyte_cnt) + CNT_W'(WORD_BYTES)) else $error("data count step"); // R9

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (acc == '0 && ibyte_cnt == '0 && dbyte_cnt == '0 && !illegal && imem_addr == '0)) else $error("start did not clear"); // R11

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb_top;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   imem_addr;
   logic [7:0]    imem_rdata;
   logic [15:0]   dmem_addr;
   logic          dmem_rd, dmem_wr;
   logic [DW-1:0] dmem_wdata, dmem_rdata;
   logic [DW-1:0] acc;
   logic          done, illegal;
   logic [31:0]   ibyte_cnt, dbyte_cnt;

   int n_cmp = 0;
   int n_bad = 0;
   int overlap = 0;

   logic [7:0]    imem    [256];
   logic [DW-1:0] dmem    [256];
   logic [DW-1:0] exp_mem [256];
   logic [DW-1:0] e_acc;
   logic          e_ill;
   logic [31:0]   e_ib, e_db;
   int            pgm_len;

   always #4 clk = ~clk;

   acc_core dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .acc(acc), .done(done), .illegal(illegal),
      .ibyte_cnt(ibyte_cnt), .dbyte_cnt(dbyte_cnt)
   );

   assign imem_rdata = imem[imem_addr[7:0]];

   always @(posedge clk) begin
      if (dmem_wr) dmem[dmem_addr[7:0]] <= dmem_wdata;
      if (dmem_rd) dmem_rdata <= dmem[dmem_addr[7:0]];
      if (dmem_rd && dmem_wr) overlap <= overlap + 1;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] apply_op(input logic [7:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      case (op)
         8'h10: return a + b;
         8'h11: return a - b;
         8'h12: return a & b;
         8'h13: return a | b;
         default: return b;
      endcase
   endfunction

   function automatic bit legal_op(input logic [7:0] op);
      return op == 8'h01 || op == 8'h02 || (op >= 8'h10 && op <= 8'h13);
   endfunction

   task automatic put_ins(input logic [7:0] op, input logic [15:0] a);
      imem[pgm_len]   = op;
      imem[pgm_len+1] = a[7:0];
      imem[pgm_len+2] = a[15:8];
      pgm_len += 3;
   endtask

   task automatic put_byte(input logic [7:0] b);
      imem[pgm_len] = b;
      pgm_len += 1;
   endtask

   task automatic fill_data();
      for (int i = 0; i < 256; i++) begin
         logic [DW-1:0] v;
         v = $urandom;
         dmem[i]    <= v;
         exp_mem[i] = v;
      end
   endtask

   task automatic model();
      int pc;
      logic [7:0] op;
      logic [15:0] a;
      pc = 0; e_acc = '0; e_ill = 1'b0; e_ib = 0; e_db = 0;
      forever begin
         op = imem[pc[7:0]];
         e_ib++;
         if (op == 8'hFF) break;
         if (!legal_op(op)) begin e_ill = 1'b1; break; end
         a = {imem[(pc+2) & 255], imem[(pc+1) & 255]};
         pc += 3; e_ib += 2; e_db += 4;
         if (op == 8'h02) exp_mem[a[7:0]] = e_acc;
         else e_acc = apply_op(op, e_acc, exp_mem[a[7:0]]);
      end
   endtask

   task automatic run_and_check(input string tag);
      int waited;
      model();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      waited = 0;
      while (!done && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      check(done == 1'b1, {"R7 done reached ", tag}, {31'd0, done}, 32'd1);
      check(acc == e_acc, {"R2 R4 R5 accumulator ", tag}, acc, e_acc);
      check(illegal == e_ill, {"R8 illegal flag ", tag}, {31'd0, illegal}, {31'd0, e_ill});
      check(ibyte_cnt == e_ib, {"R6 R9 instruction bytes ", tag}, ibyte_cnt, e_ib);
      check(dbyte_cnt == e_db, {"R9 data bytes ", tag}, dbyte_cnt, e_db);
      for (int i = 0; i < 16; i++)
         check(dmem[i] == exp_mem[i], {"R3 memory word ", tag}, dmem[i], exp_mem[i]);
      repeat (3) @(negedge clk);
      check(done && acc == e_acc && ibyte_cnt == e_ib, {"R7 held after halt ", tag}, ibyte_cnt, e_ib);
   endtask

   task automatic random_prog(input int n, input bit allow_bad);
      logic [7:0] ops [6];
      ops[0] = 8'h01; ops[1] = 8'h02; ops[2] = 8'h10;
      ops[3] = 8'h11; ops[4] = 8'h12; ops[5] = 8'h13;
      pgm_len = 0;
      for (int k = 0; k < n; k++) begin
         if (allow_bad && k == n - 1) put_byte(8'h20 + 8'($urandom_range(0, 15)));
         else put_ins(ops[$urandom_range(0, 5)], 16'($urandom_range(0, 15)));
      end
      put_byte(8'hFF);
   endtask

   initial begin
      #(8 * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240417));
      for (int i = 0; i < 256; i++) imem[i] = 8'hFF;
      fill_data();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!done && !illegal, "R1 flags after reset", {30'd0, done, illegal}, 32'd0);
      check(acc == '0, "R1 accumulator after reset", acc, 32'd0);
      check(ibyte_cnt == 0 && dbyte_cnt == 0, "R1 counters after reset", ibyte_cnt | dbyte_cnt, 32'd0);
      check(!dmem_rd && !dmem_wr, "R1 no strobe after reset", {30'd0, dmem_rd, dmem_wr}, 32'd0);

      // R4 subtract wraps, R3 store then load back
      pgm_len = 0;
      fill_data();
      dmem[0] <= 32'd5; exp_mem[0] = 32'd5;
      dmem[1] <= 32'd7; exp_mem[1] = 32'd7;
      put_ins(8'h01, 16'h0000);
      put_ins(8'h11, 16'h0001);
      put_ins(8'h02, 16'h0003);
      put_ins(8'h01, 16'h0000);
      put_ins(8'h01, 16'h0003);
      put_byte(8'hFF);
      run_and_check("sub wrap and store/load");
      check(acc == 32'hFFFF_FFFE, "R4 wrapped difference", acc, 32'hFFFF_FFFE);

      // R11 restart and R7 lone halt: counts 1 byte, acc cleared
      pgm_len = 0;
      put_byte(8'hFF);
      run_and_check("lone halt");
      check(ibyte_cnt == 1 && acc == 0, "R11 restart cleared state", ibyte_cnt, 32'd1);

      // R6 low address byte first: hi=0x01 lo=0x02
      pgm_len = 0;
      fill_data();
      dmem[2] <= 32'hA5A5_0002; exp_mem[2] = 32'hA5A5_0002;
      dmem[1] <= 32'h1111_1111; exp_mem[1] = 32'h1111_1111;
      put_ins(8'h01, 16'h0102);
      put_byte(8'hFF);
      run_and_check("address byte order");
      check(acc == 32'hA5A5_0002, "R6 operand byte order", acc, 32'hA5A5_0002);

      // R8 undefined opcode after a load
      pgm_len = 0;
      fill_data();
      put_ins(8'h01, 16'h0004);
      put_byte(8'h55);
      run_and_check("undefined opcode");
      check(illegal && ibyte_cnt == 4 && dbyte_cnt == 4, "R8 stop on bad opcode", ibyte_cnt, 32'd4);

      // R5 logic ops directed
      pgm_len = 0;
      fill_data();
      dmem[5] <= 32'hF0F0_1234; exp_mem[5] = 32'hF0F0_1234;
      dmem[6] <= 32'h0FF0_00FF; exp_mem[6] = 32'h0FF0_00FF;
      dmem[7] <= 32'h0000_0100; exp_mem[7] = 32'h0000_0100;
      put_ins(8'h01, 16'h0005);
      put_ins(8'h12, 16'h0006);
      put_ins(8'h13, 16'h0007);
      put_byte(8'hFF);
      run_and_check("and/or");
      check(acc == 32'h00F0_0134, "R5 and then or", acc, 32'h00F0_0134);

      // random programs
      for (int r = 0; r < 40; r++) begin
         fill_data();
         random_prog($urandom_range(1, 20), (r % 7) == 3);
         run_and_check("random");
      end

      check(overlap == 0, "R10 read/write overlap", overlap, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule